// File: doc/BRIEF.md
# DRAM Refresh Cycle Sequencer

This block issues single refresh cycles to an asynchronous DRAM with a multiplexed address bus. It has two refresh styles. In the address-driven style the block places a row number on the address bus, pulls the row strobe low and holds the column strobe high for the whole cycle. In the column-first style the column strobe falls ahead of the row strobe, the device uses its own internal row pointer, and the block drives the address bus to zero. All analog timing minimums are turned into whole controller clock cycles at elaboration time. The conversion uses the clock period and a speed-grade parameter, and every value is rounded up.

A refresh scheduler outside this block pulses `refresh_req` and chooses the style with `refresh_cbr`. The block answers with `busy` for the whole protected cycle and then a one-cycle `done`. For the address-driven style it keeps a wrapping row counter. The write-enable and output-enable strobes stay high at all times, and the data bus is never enabled. With the defaults (10 ns clock, fastest grade) one cycle has 1 setup cycle, 6 strobe-low cycles and 4 precharge cycles, so `busy` lasts 11 cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and after reset, until the first request, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, `busy`, `done` and `dq_oe` are 0, and `row_addr` is 0.
- R2: A request is accepted only while `busy` is 0. A request raised while `busy` is 1 starts no cycle, and it does not advance the row counter.
- R3: In an address-driven cycle (`refresh_cbr`=0), `cas_n` stays 1 throughout. `row_addr` carries the row counter value from the first `busy` cycle until `ras_n` rises, and it is stable while `ras_n` is 0. `ras_n` falls S cycles after `busy` rises, where S = max(1, ceil(tASR), ceil(tWRP)), which is 1 by default.
- R4: In a column-first cycle (`refresh_cbr`=1), `cas_n` falls together with `busy` rising and `row_addr` stays 0. `ras_n` falls S = max(1, ceil(tCSR), ceil(tWRP)) cycles later, which is 1 by default. `cas_n` stays 0 until it rises together with `ras_n`.
- R5: `ras_n` stays 0 for exactly A = max(ceil(tRAS min), ceil(tRAH), ceil(tCHR), ceil(tWRH)) cycles, which is 6 by default (60 ns at 10 ns).
- R6: After `ras_n` rises, `busy` stays 1 for P more cycles with `ras_n` high. P = max(ceil(tRP), ceil(tRC) - S - A, ceil(tCP), ceil(tRPC), ceil(tCRP)), which is 4 by default, so the busy window covers at least ceil(tRC) = 11 cycles. `ras_n` is never 0 while `busy` is 0.
- R7: `done` is 1 for exactly one cycle, the first cycle in which `busy` is 0 after a refresh, and it is never 1 while `busy` is 1.
- R8: The row counter starts at 0 and advances by one after each address-driven cycle. It wraps from ROWS-1 to 0. Column-first cycles leave it unchanged.
- R9: `we_n` and `oe_n` are 1 and `dq_oe` is 0 in every cycle.
- R10: While `refresh_req` is held at 1, the next cycle is accepted in the `done` cycle, so exactly one non-busy cycle separates two refreshes.
- R11: The style is sampled only at acceptance. A change of `refresh_cbr` during a cycle does not alter that cycle's strobe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_req | input | 1 | Request one refresh cycle |
| refresh_cbr | input | 1 | 1 = column-first style, 0 = address-driven style |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |
| dq_oe | output | 1 | Data bus drive enable, held low |
| row_addr | output | ROW_W | Multiplexed address bus (row during address-driven cycles) |
| busy | output | 1 | Refresh cycle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The sequence starts with isolated address-driven cycles and then a column-first cycle between two address-driven ones. This shows whether the strobe order follows the sampled style and whether only address-driven cycles advance the row. A run through four rows with a small row count shows the wrap. A request raised inside a busy window, together with a flipped style input, tells a design that ignores both from one that restarts or switches style mid-cycle. A request held high over two cycles of each style shows whether the block re-accepts in the done cycle with the single idle cycle between refreshes.

// File: rtl/dref_pkg.sv
// Package dref_pkg
// Shared types and elaboration-time helpers for the refresh sequencer.
// Assumes all timing inputs are integral nanoseconds and the clock
// period is a positive integral number of nanoseconds.
package dref_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_PRECH  = 2'd3
    } phase_t;

    typedef enum logic {
        STYLE_ADDR = 1'b0,
        STYLE_CBR  = 1'b1
    } rstyle_t;

    // Grade-independent minimums in nanoseconds
    localparam int T_ASR_NS = 0;
    localparam int T_RAH_NS = 10;
    localparam int T_CSR_NS = 10;
    localparam int T_CHR_NS = 15;
    localparam int T_CP_NS  = 10;
    localparam int T_RPC_NS = 5;
    localparam int T_CRP_NS = 5;
    localparam int T_WRP_NS = 10;
    localparam int T_WRH_NS = 10;

    // Round a nanosecond figure up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Minimum row-strobe low width per speed grade (0 fastest)
    function automatic int ras_low_ns(input int grade);
        case (grade)
            0:       return 60;
            1:       return 70;
            default: return 80;
        endcase
    endfunction

    // Minimum row-strobe precharge per speed grade
    function automatic int ras_prech_ns(input int grade);
        case (grade)
            0:       return 40;
            1:       return 50;
            default: return 60;
        endcase
    endfunction

    // Minimum full cycle time per speed grade
    function automatic int cycle_ns(input int grade);
        case (grade)
            0:       return 110;
            1:       return 130;
            default: return 150;
        endcase
    endfunction

endpackage

// File: rtl/dref_phase_seq.sv
// Module dref_phase_seq
// Phase controller: idle -> setup -> strobe-low -> precharge -> idle.
// A single down-counter times every phase; its reload value is picked
// on each phase entry. Requests are taken only in idle, and the style
// is captured at that moment. Next-phase and next-style values are
// exported so the pin stage can register its outputs in step.
// Assumes every length parameter is at least 1.
module dref_phase_seq
    import dref_pkg::*;
#(
    parameter int SETUP_ADDR = 1,
    parameter int SETUP_CBR  = 1,
    parameter int ACT_LEN    = 6,
    parameter int PRE_LEN    = 4,
    parameter int CW         = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req,
    input  logic    style_in,
    output phase_t  phase_nx,
    output rstyle_t style_nx,
    output logic    row_step,
    output logic    done_q
);

    phase_t        phase_q;
    rstyle_t       style_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          last;

    assign last = (cnt_q == '0);

    // Next-state decode for phase, counter and captured style
    always_comb begin
        phase_nx = phase_q;
        style_nx = style_q;
        cnt_nx   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        case (phase_q)
            PH_IDLE: begin
                if (req) begin
                    phase_nx = PH_SETUP;
                    style_nx = rstyle_t'(style_in);
                    cnt_nx   = style_in ? CW'(SETUP_CBR - 1) : CW'(SETUP_ADDR - 1);
                end
            end
            PH_SETUP: begin
                if (last) begin
                    phase_nx = PH_ACTIVE;
                    cnt_nx   = CW'(ACT_LEN - 1);
                end
            end
            PH_ACTIVE: begin
                if (last) begin
                    phase_nx = PH_PRECH;
                    cnt_nx   = CW'(PRE_LEN - 1);
                end
            end
            default: begin
                if (last) begin
                    phase_nx = PH_IDLE;
                end
            end
        endcase
    end

    // Phase, counter and style registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            style_q <= STYLE_ADDR;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_nx;
            style_q <= style_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // Completion pulse in the first idle cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_PRECH) && last;
        end
    end

    // Row advance at the end of an address-driven strobe-low phase
    assign row_step = (phase_q == PH_ACTIVE) && last && (style_q == STYLE_ADDR);

endmodule

// File: rtl/dref_row_ctr.sv
// Module dref_row_ctr
// Wrapping row pointer for address-driven refresh. It advances by one
// on each step pulse and returns to zero after ROWS-1.
// Assumes ROWS fits in ROW_W bits.
module dref_row_ctr #(
    parameter int ROWS  = 4096,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    // Advance or wrap the row pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= (row == ROW_LAST) ? '0 : row + 1'b1;
        end
    end

endmodule

// File: rtl/dref_pin_drv.sv
// Module dref_pin_drv
// Registers the DRAM strobes, the address bus and busy from the
// next-phase decode, so all pins change on the same edge as the phase.
// Assumes the row input is stable from acceptance to the strobe rise.
module dref_pin_drv
    import dref_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase_nx,
    input  rstyle_t          style_nx,
    input  logic [ROW_W-1:0] row,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] addr,
    output logic             busy
);

    logic strobe_window;

    assign strobe_window = (phase_nx == PH_SETUP) || (phase_nx == PH_ACTIVE);

    // Registered strobe, address and busy outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            addr  <= '0;
            busy  <= 1'b0;
        end else begin
            ras_n <= (phase_nx != PH_ACTIVE);
            cas_n <= !(strobe_window && (style_nx == STYLE_CBR));
            addr  <= (strobe_window && (style_nx == STYLE_ADDR)) ? row : '0;
            busy  <= (phase_nx != PH_IDLE);
        end
    end

endmodule

// File: rtl/dram_refresh_seq.sv
// Module dram_refresh_seq
// Top of the refresh sequencer. It converts the nanosecond minimums to
// cycle counts for the chosen clock period and grade, and joins the
// phase controller, row pointer and pin stage. Write enable and output
// enable are tied high and the data bus enable is tied low.
// Assumes CLK_NS > 0 and that ACT_CYC * CLK_NS stays under the 10 us
// maximum strobe-low width.
module dram_refresh_seq
    import dref_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int SPEED_GRADE = 0,
    parameter int ROWS        = 4096,
    parameter int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_req,
    input  logic             refresh_cbr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe,
    output logic [ROW_W-1:0] row_addr,
    output logic             busy,
    output logic             done
);

    localparam int RAS_CYC    = ns_to_cyc(ras_low_ns(SPEED_GRADE), CLK_NS);
    localparam int RP_CYC     = ns_to_cyc(ras_prech_ns(SPEED_GRADE), CLK_NS);
    localparam int RC_CYC     = ns_to_cyc(cycle_ns(SPEED_GRADE), CLK_NS);
    localparam int WRP_CYC    = ns_to_cyc(T_WRP_NS, CLK_NS);
    localparam int SETUP_ADDR = imax(1, imax(ns_to_cyc(T_ASR_NS, CLK_NS), WRP_CYC));
    localparam int SETUP_CBR  = imax(1, imax(ns_to_cyc(T_CSR_NS, CLK_NS), WRP_CYC));
    localparam int SETUP_MAX  = imax(SETUP_ADDR, SETUP_CBR);
    localparam int ACT_CYC    = imax(imax(RAS_CYC, ns_to_cyc(T_RAH_NS, CLK_NS)),
                                     imax(ns_to_cyc(T_CHR_NS, CLK_NS),
                                          ns_to_cyc(T_WRH_NS, CLK_NS)));
    localparam int PRE_EDGE   = imax(ns_to_cyc(T_CP_NS, CLK_NS),
                                     imax(ns_to_cyc(T_RPC_NS, CLK_NS),
                                          ns_to_cyc(T_CRP_NS, CLK_NS)));
    localparam int PRE_CYC    = imax(imax(RP_CYC, RC_CYC - SETUP_MAX - ACT_CYC),
                                     imax(PRE_EDGE, 1));
    localparam int LEN_MAX    = imax(imax(SETUP_MAX, ACT_CYC), PRE_CYC);
    localparam int CW         = $clog2(LEN_MAX + 1);

    phase_t           phase_nx;
    rstyle_t          style_nx;
    logic             row_step;
    logic [ROW_W-1:0] row;

    dref_phase_seq #(
        .SETUP_ADDR (SETUP_ADDR),
        .SETUP_CBR  (SETUP_CBR),
        .ACT_LEN    (ACT_CYC),
        .PRE_LEN    (PRE_CYC),
        .CW         (CW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (refresh_req),
        .style_in (refresh_cbr),
        .phase_nx (phase_nx),
        .style_nx (style_nx),
        .row_step (row_step),
        .done_q   (done)
    );

    dref_row_ctr #(
        .ROWS  (ROWS),
        .ROW_W (ROW_W)
    ) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_step),
        .row   (row)
    );

    dref_pin_drv #(
        .ROW_W (ROW_W)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_nx (phase_nx),
        .style_nx (style_nx),
        .row      (row),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .addr     (row_addr),
        .busy     (busy)
    );

    // Strobes the refresh never uses, parked inactive
    assign we_n  = 1'b1;
    assign oe_n  = 1'b1;
    assign dq_oe = 1'b0;

endmodule

// File: rtl/dref_checker.sv
// Module dref_checker
// Port-level protocol checks for the refresh sequencer, bound to the
// top module. It counts strobe-low and strobe-high runs in local
// counters so that widths are checked without deep history.
module dref_checker #(
    parameter int ROW_W = 12,
    parameter int A_CYC = 6,
    parameter int P_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             dq_oe,
    input logic [ROW_W-1:0] row_addr,
    input logic             busy,
    input logic             done
);

    logic [15:0] low_cnt;
    logic [15:0] high_cnt;
    logic        busy_d;
    logic        cbr_seen;

    // Run-length counters for the row strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            low_cnt  <= ras_n ? '0 : ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1);
            high_cnt <= !ras_n ? '0 : ((high_cnt == 16'hFFFF) ? high_cnt : high_cnt + 1'b1);
        end
    end

    // Record the style of the cycle from the column strobe at its start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_d   <= 1'b0;
            cbr_seen <= 1'b0;
        end else begin
            busy_d <= busy;
            if (busy && !busy_d) begin
                cbr_seen <= !cas_n;
            end
        end
    end

    assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ras_n && cas_n));

    assert_addr_cas_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_d && !cbr_seen) |-> cas_n);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> $stable(row_addr));

    assert_cas_steady_at_ras_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(cas_n));

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && !$past(ras_n)) |-> (low_cnt == 16'(A_CYC)));

    assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (high_cnt == 16'(P_CYC)));

    assert_ras_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> busy);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_parked_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we_n && oe_n && !dq_oe);

endmodule

bind dram_refresh_seq dref_checker #(
    .ROW_W (ROW_W),
    .A_CYC (ACT_CYC),
    .P_CYC (PRE_CYC)
) u_dref_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .row_addr (row_addr),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_dram_refresh_seq.sv
// Scoreboard bench: driver tasks queue the expected cycles, and a
// monitor measures each busy window at the ports and compares.
module tb_dram_refresh_seq;

    localparam int TB_ROWS = 4;
    localparam int TB_RW   = 2;
    // Expected phase lengths from the requirements at 10 ns, grade 0
    localparam int EXP_S = 1;   // R3/R4: ceil(10 ns / 10 ns)
    localparam int EXP_A = 6;   // R5: ceil(60 / 10)
    localparam int EXP_P = 4;   // R6: max(ceil(40/10), 11 - 1 - 6)

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             refresh_req = 1'b0;
    logic             refresh_cbr = 1'b0;
    logic             ras_n, cas_n, we_n, oe_n, dq_oe, busy, done;
    logic [TB_RW-1:0] row_addr;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        bit cbr;
        int row;
        bit b2b;
    } exp_t;

    exp_t exp_q[$];
    int   model_row = 0;

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .CLK_NS      (10),
        .SPEED_GRADE (0),
        .ROWS        (TB_ROWS)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_req (refresh_req),
        .refresh_cbr (refresh_cbr),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .dq_oe       (dq_oe),
        .row_addr    (row_addr),
        .busy        (busy),
        .done        (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic exp_t make_item(input bit cbr, input bit b2b);
        exp_t it;
        it.cbr = cbr;
        it.b2b = b2b;
        it.row = cbr ? 0 : model_row;
        if (!cbr) model_row = (model_row + 1) % TB_ROWS;   // R8 model
        return it;
    endfunction

    task automatic wait_quiet();
        do @(negedge clk); while (busy || exp_q.size() != 0);
        repeat (2) @(negedge clk);
    endtask

    // One isolated refresh of the given style
    task automatic do_refresh(input bit cbr);
        exp_q.push_back(make_item(cbr, 1'b0));
        @(negedge clk);
        refresh_req = 1'b1;
        refresh_cbr = cbr;
        @(negedge clk);
        refresh_req = 1'b0;
        wait_quiet();
    endtask

    // Refresh with a second request and a flipped style inside busy (R2, R11)
    task automatic do_poked(input bit cbr);
        exp_q.push_back(make_item(cbr, 1'b0));
        @(negedge clk);
        refresh_req = 1'b1;
        refresh_cbr = cbr;
        @(negedge clk);
        refresh_req = 1'b0;
        repeat (2) @(negedge clk);
        refresh_req = 1'b1;
        refresh_cbr = !cbr;
        repeat (3) @(negedge clk);
        refresh_req = 1'b0;
        wait_quiet();
    endtask

    // Request held over two cycles (R10)
    task automatic do_b2b(input bit cbr);
        exp_q.push_back(make_item(cbr, 1'b0));
        exp_q.push_back(make_item(cbr, 1'b1));
        @(negedge clk);
        refresh_req = 1'b1;
        refresh_cbr = cbr;
        repeat (13) @(negedge clk);
        refresh_req = 1'b0;
        wait_quiet();
    endtask

    // Monitor: measures each busy window and compares with the queue
    initial begin : monitor
        exp_t cur;
        bit   prev_busy = 1'b0;
        bit   prev_done = 1'b0;
        bit   active    = 1'b0;
        bit   seen_fall = 1'b0;
        int   n_setup = 0, n_low = 0, n_post = 0, gap = 100;
        int   cas_bad = 0, addr_bad = 0, pin_bad = 0, row_seen = 0;
        cur = '{cbr: 1'b0, row: 0, b2b: 1'b0};
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (!we_n || !oe_n || dq_oe) pin_bad++;
            if (busy && !prev_busy) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected refresh start", 1, 0);
                    active = 1'b0;
                end else begin
                    cur = exp_q.pop_front();
                    active = 1'b1;
                    if (cur.b2b) chk(gap == 1, "R10", "idle cycles between refreshes", gap, 1);
                end
                seen_fall = 1'b0;
                n_setup = 0; n_low = 0; n_post = 0;
                cas_bad = 0; addr_bad = 0; row_seen = -1;
            end
            if (busy) begin
                if (done) chk(1'b0, "R7", "done while busy", 1, 0);
                if (ras_n && !seen_fall) begin
                    n_setup++;
                    if (cas_n != !cur.cbr) cas_bad++;
                    if (int'(row_addr) != cur.row) addr_bad++;
                end else if (!ras_n) begin
                    if (!seen_fall) row_seen = int'(row_addr);
                    seen_fall = 1'b1;
                    n_low++;
                    if (cas_n != !cur.cbr) cas_bad++;
                    if (int'(row_addr) != cur.row) addr_bad++;
                end else begin
                    n_post++;
                    if (!cas_n) cas_bad++;
                end
            end
            if (!busy && prev_busy && active) begin
                string mreq;
                mreq = cur.cbr ? "R4" : "R3";
                chk(done == 1'b1, "R7", "done on first idle cycle", done, 1);
                chk(n_setup == EXP_S, mreq, "cycles before row strobe falls", n_setup, EXP_S);
                chk(n_low == EXP_A, "R5", "row strobe low cycles", n_low, EXP_A);
                chk(n_post == EXP_P, "R6", "precharge cycles inside busy", n_post, EXP_P);
                chk(cas_bad == 0, "R11", "column strobe pattern vs sampled style", cas_bad, 0);
                chk(addr_bad == 0, mreq, "address samples off", addr_bad, 0);
                if (!cur.cbr) chk(row_seen == cur.row, "R8", "row at strobe fall", row_seen, cur.row);
                chk(pin_bad == 0, "R9", "parked pins disturbed", pin_bad, 0);
                active = 1'b0;
                gap = 0;
            end
            if (!busy) begin
                gap++;
                if (prev_done && done) chk(1'b0, "R7", "done longer than one cycle", 2, 1);
            end
            prev_busy = busy;
            prev_done = done;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 100000, 0);
        finish_run();
    end

    // Stimulus
    initial begin : driver
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(ras_n && cas_n, "R1", "strobes high in reset", {ras_n, cas_n}, 3);
        chk(!busy && !done, "R1", "busy/done low in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs after reset, before any request
        chk(ras_n && cas_n, "R1", "strobes high after reset", {ras_n, cas_n}, 3);
        chk(we_n && oe_n && !dq_oe, "R1", "parked pins after reset", {we_n, oe_n, dq_oe}, 6);
        chk(row_addr == '0, "R1", "address zero after reset", int'(row_addr), 0);
        chk(!busy && !done, "R1", "busy/done low after reset", {busy, done}, 0);

        do_refresh(1'b0);       // R3 row 0
        do_refresh(1'b0);       // R3 row 1
        do_refresh(1'b1);       // R4, R8: no row advance
        do_refresh(1'b0);       // row 2
        do_refresh(1'b0);       // row 3
        do_refresh(1'b0);       // R8 wrap to row 0
        do_poked(1'b0);         // R2, R11 row 1
        do_poked(1'b1);         // R2, R11 column-first
        do_refresh(1'b0);       // R2: row 2 shows no extra advance
        do_b2b(1'b1);           // R10 column-first pair
        do_b2b(1'b0);           // R10 address-driven pair, rows 3 and 0

        chk(exp_q.size() == 0, "R2", "expected cycles left unserved", exp_q.size(), 0);
        finish_run();
    end

endmodule